// File: doc/BRIEF.md
# Memory Refresh Interval Timer

This block produces periodic refresh requests for dynamic memory. A power-of-two prescaler divides the system clock. The divisor is chosen by a 3-bit select code. An 8-bit interval counter advances once per prescaled tick and is compared with an 8-bit interval constant. When the counter reaches the constant, the block sets a sticky match flag and raises `refresh_req` for exactly one clock. The counter then restarts from zero on the following tick. A request is therefore issued every (constant + 1) prescaled ticks.

Software reaches three 8-bit registers through a plain write/read port: a control/status register, the counter and the constant. Every write must carry the guard key 0xA55A in bits 31:16 of the write word. A write without that key changes nothing. Reads are combinational on the address and zero-extended to 32 bits. The memory controller that consumes the request is outside this block.

Top module: `rfsh_interval_timer`

## Requirements
- R1: After a synchronous active-low reset, the control/status register reads 0, the counter reads 0, the constant reads 0xFF and `refresh_req` is 0.
- R2: With select code 0 in control bits 5:3, the prescaler and the counter are halted, and no request is issued.
- R3: Select codes 1 to 7 in control bits 5:3 give divisors 4, 16, 64, 256, 1024, 2048 and 4096. The counter advances by one every divisor clocks.
- R4: On the tick that brings the counter to the constant, the match flag (control bit 7) and `refresh_req` both go high one clock later. `refresh_req` lasts one clock. The next tick clears the counter, so requests repeat every (constant+1)·divisor clocks.
- R5: A constant of 0 makes every prescaled tick issue a request, which gives an interval of exactly one divisor.
- R6: A write whose bits 31:16 differ from 0xA55A changes no register.
- R7: A keyed write to the control register with bit 7 at 0 clears the match flag, and a 1 in bit 7 leaves the flag as it is. A match in the same clock sets the flag, and this takes priority over the clear.
- R8: A keyed write to address 1 loads the counter from bits 7:0. The load takes precedence over a tick in the same clock, and no match is raised that clock.
- R9: Reads are combinational on `addr`. Address 0 returns the flag at bit 7 and the select at bits 5:3. Address 1 returns the counter, address 2 returns the constant, and address 3 returns 0. Bits 31:8 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 counter, 2 constant) |
| wdata | input | 32 | Write word, guard key in bits 31:16 |
| rdata | output | 32 | Read data for `addr` |
| refresh_req | output | 1 | One-clock refresh request pulse |

## Verification
The interval logic is exercised with three patterns:
- A constant of 3 at the smallest divisor checks the counter's wrap and the 16-clock request spacing.
- A constant of 0 swept through every select code measures each divisor on its own. This tells a wrong code-to-divisor mapping apart from a wrong compare.
- A counter loaded above the constant, with the timer halted, shows that a load overrides counting.

Writes with a bad key, and flag writes carrying 1 and 0, show that the guard and the clear act independently. A behavioural model compares the request and the read word on every clock.

// File: rtl/rit_pkg.sv
// Shared constants and helpers for the refresh interval timer.
// Assumes power-of-two divisors so a tick is an all-ones test of low prescaler bits.
package rit_pkg;
    localparam int SEL_W     = 3;
    localparam int NUM_CODES = 1 << SEL_W;
    localparam int FLAG_BIT  = 7;
    localparam int SEL_LSB   = 3;

    typedef logic [SEL_W-1:0] clk_sel_t;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_COUNT = 2'd1,
        A_CONST = 2'd2,
        A_NONE  = 2'd3
    } reg_addr_e;

    // log2 of the divisor for a select code; 0 means stopped.
    function automatic int sel_shift(input int code);
        if (code == 0)      return 0;
        else if (code <= 4) return 2 * code;
        else                return code + 5;
    endfunction

    localparam int PRE_W = sel_shift(NUM_CODES - 1);
endpackage

// File: rtl/rit_prescaler.sv
// Prescaler: a free-running counter whose low bits, selected by code,
// produce a one-clock tick every 2^shift clocks. Code 0 holds it at zero.
module rit_prescaler
    import rit_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  clk_sel_t sel,
    output logic     tick
);
    logic [PRE_W-1:0]     pre_q;
    logic [NUM_CODES-1:0] tap;

    // Advance the prescale count while a divisor is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)          pre_q <= '0;
        else if (sel == '0)  pre_q <= '0;
        else                 pre_q <= pre_q + 1'b1;
    end

    assign tap[0] = 1'b0;
    for (genvar c = 1; c < NUM_CODES; c++) begin : g_tap
        localparam int SH = sel_shift(c);
        assign tap[c] = &pre_q[SH-1:0];
    end

    assign tick = tap[sel];
endmodule

// File: rtl/rit_compare.sv
// Interval counter, compare, sticky flag and registered request pulse.
// Assumes ticks are at least two clocks apart (smallest divisor is 4).
module rit_compare #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cst,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             req
);
    logic [CNT_W-1:0] next_val;
    logic             hit;

    // Value the counter takes on a tick, and whether that value matches.
    always_comb begin
        next_val = (cnt == cst) ? '0 : cnt + 1'b1;
        hit      = tick && !load_en && (next_val == cst);
    end

    // Counter: a software load wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load_en) cnt <= load_val;
        else if (tick)    cnt <= next_val;
    end

    // Sticky flag: a match sets it with priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // One-clock request aligned with the flag setting.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= hit;
    end
endmodule

// File: rtl/rit_regs.sv
// Key-guarded register port: holds select and constant, decodes loads and
// flag clears, and muxes the zero-extended read word.
module rit_regs
    import rit_pkg::*;
#(
    parameter int             DATA_W    = 32,
    parameter int             CNT_W     = 8,
    parameter int             KEY_W     = 16,
    parameter logic [KEY_W-1:0] KEY     = 16'hA55A,
    parameter logic [CNT_W-1:0] RST_CST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              flag,
    output clk_sel_t          cks,
    output logic [CNT_W-1:0]  cst,
    output logic              load_en,
    output logic [CNT_W-1:0]  load_val,
    output logic              flag_clr,
    output logic [DATA_W-1:0] rdata
);
    logic      key_ok;
    reg_addr_e a;
    logic      unused_bits;

    assign a           = reg_addr_e'(addr);
    assign key_ok      = wr_en && (wdata[DATA_W-1 -: KEY_W] == KEY);
    assign load_en     = key_ok && (a == A_COUNT);
    assign load_val    = wdata[CNT_W-1:0];
    assign flag_clr    = key_ok && (a == A_CTRL) && !wdata[FLAG_BIT];
    assign unused_bits = ^wdata[DATA_W-KEY_W-1:CNT_W] ^ wdata[SEL_LSB-1] ^ wdata[SEL_LSB-2]
                         ^ wdata[0] ^ wdata[6];

    // Control register: clock select field.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cks <= '0;
        else if (key_ok && a == A_CTRL)  cks <= wdata[SEL_LSB +: SEL_W];
    end

    // Constant register.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cst <= RST_CST;
        else if (key_ok && a == A_CONST) cst <= wdata[CNT_W-1:0];
    end

    // Read mux, zero-extended.
    always_comb begin
        rdata = '0;
        case (a)
            A_CTRL: begin
                rdata[FLAG_BIT]            = flag;
                rdata[SEL_LSB +: SEL_W]    = cks;
            end
            A_COUNT: rdata[CNT_W-1:0] = cnt;
            A_CONST: rdata[CNT_W-1:0] = cst;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/rfsh_interval_timer.sv
// Top: prescaler, interval compare and key-guarded register port.
// Assumes one synchronous clock domain and a synchronous active-low reset.
module rfsh_interval_timer
    import rit_pkg::*;
#(
    parameter int               DATA_W  = 32,
    parameter int               CNT_W   = 8,
    parameter int               KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY     = 16'hA55A,
    parameter logic [CNT_W-1:0] RST_CST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              refresh_req
);
    clk_sel_t         cks_q;
    logic [CNT_W-1:0] cst_q;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             tick;
    logic             load_en;
    logic [CNT_W-1:0] load_val;
    logic             flag_clr;

    rit_prescaler u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (cks_q),
        .tick (tick)
    );

    rit_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cst     (cst_q),
        .load_en (load_en),
        .load_val(load_val),
        .flag_clr(flag_clr),
        .cnt     (cnt_q),
        .flag    (flag_q),
        .req     (refresh_req)
    );

    rit_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .KEY_W  (KEY_W),
        .KEY    (KEY),
        .RST_CST(RST_CST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .cnt     (cnt_q),
        .flag    (flag_q),
        .cks     (cks_q),
        .cst     (cst_q),
        .load_en (load_en),
        .load_val(load_val),
        .flag_clr(flag_clr),
        .rdata   (rdata)
    );
endmodule

// File: rtl/rit_checker.sv
// Protocol checker for the refresh interval timer, bound to the top.
module rit_checker
    import rit_pkg::*;
#(
    parameter int               DATA_W = 32,
    parameter int               CNT_W  = 8,
    parameter int               KEY_W  = 16,
    parameter logic [KEY_W-1:0] KEY    = 16'hA55A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              refresh_req,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  cst_q,
    input clk_sel_t          cks_q,
    input logic              flag_q
);
    logic good_key;
    logic unused_lo;
    assign good_key  = wdata[DATA_W-1 -: KEY_W] == KEY;
    assign unused_lo = ^rdata[CNT_W-1:0] ^ ^wdata[DATA_W-KEY_W-1:FLAG_BIT+1];

    p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> !refresh_req);

    p_req_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> flag_q);

    p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cks_q == '0 && !(wr_en && good_key && addr == 2'd1)) |=> $stable(cnt_q));

    p_badkey_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !good_key) |=> ($stable(cks_q) && $stable(cst_q)));

    p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && good_key && addr == 2'd0 && !wdata[FLAG_BIT]) |=> (!flag_q || refresh_req));

    p_rd_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:CNT_W] == '0);
endmodule

bind rfsh_interval_timer rit_checker #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .refresh_req(refresh_req),
    .cnt_q      (cnt_q),
    .cst_q      (cst_q),
    .cks_q      (cks_q),
    .flag_q     (flag_q)
);

// File: tb/tb_rfsh_interval_timer.sv
`timescale 1ns/1ps
module tb_rfsh_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        refresh_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int pulses = 0;
    int last_pulse = 0;

    // Reference model state
    int m_pre = 0, m_cks = 0, m_cst = 255, m_cnt = 0;
    bit m_flag = 0, m_req = 0;

    always #10 clk = ~clk;

    rfsh_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .refresh_req(refresh_req)
    );

    function automatic int m_div(input int c);
        case (c)
            1: return 4;     2: return 16;    3: return 64;
            4: return 256;   5: return 1024;  6: return 2048;
            7: return 4096;  default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return (32'(m_flag) << 7) | (32'(m_cks) << 3);
            2'd1: return 32'(m_cnt);
            2'd2: return 32'(m_cst);
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference model: behavioural update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cks = 0; m_cst = 255; m_cnt = 0; m_flag = 0; m_req = 0;
        end else begin
            bit keyok, tk, match;
            int nx;
            keyok = wr_en && (wdata[31:16] == 16'hA55A);
            tk = (m_cks != 0) && ((m_pre % m_div(m_cks)) == m_div(m_cks) - 1);
            match = 0;
            m_pre = (m_cks == 0) ? 0 : (m_pre + 1) % 4096;
            if (keyok && addr == 2'd1) m_cnt = int'(wdata[7:0]);
            else if (tk) begin
                nx = (m_cnt == m_cst) ? 0 : (m_cnt + 1) % 256;
                m_cnt = nx;
                match = (nx == m_cst);
            end
            if (keyok && addr == 2'd0 && !wdata[7]) m_flag = 0;
            if (match) m_flag = 1;
            if (keyok && addr == 2'd0) m_cks = int'(wdata[5:3]);
            if (keyok && addr == 2'd2) m_cst = int'(wdata[7:0]);
            m_req = match;
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check("R4 model refresh_req", 32'(refresh_req), 32'(m_req));
            check("R9 model rdata", rdata, m_read(addr));
            if (refresh_req) begin
                pulses++;
                last_pulse = cyc;
            end
        end
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr_en = 1'b0; wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        addr = a; #2;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic wait_pulse();
        int p0;
        p0 = pulses;
        for (int i = 0; i < 10000 && pulses == p0; i++) begin
            @(negedge clk); #1;
        end
    endtask

    initial begin
        logic [31:0] v;
        int t1, iv, p0;
        idle(5);
        @(negedge clk); #1 rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, v); check("R1 ctrl after reset", v, 32'h0);
        rd(2'd1, v); check("R1 counter after reset", v, 32'h0);
        rd(2'd2, v); check("R1 constant after reset", v, 32'hFF);
        check("R1 refresh_req after reset", 32'(refresh_req), 32'h0);

        // R2: select 0 halts everything
        p0 = pulses;
        idle(60);
        rd(2'd1, v); check("R2 counter halted", v, 32'h0);
        check("R2 no requests while halted", 32'(pulses), 32'(p0));

        // R6: wrong key ignored
        wr(2'd0, 32'h1234_0008);
        wr(2'd2, 32'h0000_0003);
        wr(2'd1, 32'hA55B_0042);
        rd(2'd0, v); check("R6 ctrl unchanged by bad key", v, 32'h0);
        rd(2'd2, v); check("R6 constant unchanged by bad key", v, 32'hFF);
        rd(2'd1, v); check("R6 counter unchanged by bad key", v, 32'h0);

        // R3/R4: constant 3, divisor 4 -> request every 16 clocks
        wr(2'd2, 32'hA55A_0003);
        wr(2'd0, 32'hA55A_0008);
        wait_pulse(); t1 = last_pulse;
        rd(2'd0, v); check("R4 flag set after match", v & 32'h80, 32'h80);
        wait_pulse(); iv = last_pulse - t1;
        check("R4 interval const 3 div 4", 32'(iv), 32'd16);
        t1 = last_pulse; wait_pulse(); iv = last_pulse - t1;
        check("R4 interval repeats", 32'(iv), 32'd16);

        // R7: stop, then write 1 (no effect) and 0 (clear) to the flag
        wr(2'd0, 32'hA55A_0080);
        rd(2'd0, v); check("R7 writing 1 keeps flag", v, 32'h80);
        wr(2'd0, 32'hA55A_0000);
        rd(2'd0, v); check("R7 writing 0 clears flag", v, 32'h0);

        // R8: counter load while halted
        wr(2'd1, 32'hA55A_0080);
        idle(20);
        rd(2'd1, v); check("R8 counter loaded", v, 32'h80);

        // R9: unused address reads zero
        rd(2'd3, v); check("R9 address 3 reads zero", v, 32'h0);

        // R5/R3: constant 0, every select code
        wr(2'd2, 32'hA55A_0000);
        for (int c = 1; c < 8; c++) begin
            wr(2'd0, 32'hA55A_0000 | (32'(c) << 3));
            wait_pulse();
            wait_pulse(); t1 = last_pulse;
            wait_pulse(); iv = last_pulse - t1;
            check($sformatf("R3 R5 interval for code %0d", c), 32'(iv), 32'(m_div(c)));
        end
        wr(2'd0, 32'hA55A_0000);
        rd(2'd0, v); check("R2 select back to zero", v, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule